// File: doc/BRIEF.md
# Four-Thread Packed-Integer SIMD Execution Pipe

This block executes one integer instruction per clock for a group of four threads. Each thread owns a 32-bit lane and a private 16-entry register file. A single issued instruction carries one opcode, one element mode, two operand sources, a destination, a writeback enable and a per-thread active mask. All four lanes run that instruction on their own data in the same cycle. In the narrower element modes a lane is treated as two 16-bit or four 8-bit independent values.

An operand can come from the lane's register file, from a broadcast immediate, from the lane's thread index, or from a short-lived temporary: the lane's result of the immediately preceding cycle. The temporary lets a chain of dependent instructions inside one clause skip the register file entirely. It is valid only for the very next instruction, and only when that instruction is flagged as a continuation of the same clause. Any other use raises an error flag and drops the instruction.

Top module: `qsimd_pipe`

## Requirements
- R1: There are four 32-bit lanes. Lane l computes only from thread l's operands, and its result appears on `res_data[32*l+31:32*l]`.
- R2: A valid instruction sampled at a rising edge produces `res_valid` and `res_data` after that edge. One instruction is accepted every clock. A cycle with `iss_valid` low yields `res_valid` low and `tmp_err` low after the edge.
- R3: `iss_op` encodes the operation: 0 add, 1 subtract (A minus B), 2 AND, 3 OR, 4 XOR, 5 shift A left by `iss_shamt`. Codes 6 and 7 pass A through. Every operation is applied per element.
- R4: `iss_mode` encodes the element width: 0 means one 32-bit element, 1 means two 16-bit elements, 2 means four 8-bit elements, and 3 acts as 0. Add and subtract never carry or borrow across an element boundary, and each element wraps modulo its own width.
- R5: A left shift uses the shift count modulo the element width. Bits shifted past an element's top are lost, and zeros enter at its bottom.
- R6: `iss_src_a` and `iss_src_b` select the operand source: 0 is the register selected by `iss_ra` or `iss_rb`, 1 is the temporary, 2 is `iss_imm`, and 3 is the lane's thread index. Every register reads zero after reset. A result is written to register `iss_rd` only when `iss_wb_en` is 1, and a following instruction reads the new value.
- R7: A lane whose `iss_active` bit is 0 still computes and shows its result on `res_data`, but its register file is not written.
- R8: Selecting the temporary (source code 1) yields that lane's result from the previous cycle. This holds when the previous cycle produced a valid result and `iss_clause_cont` is 1.
- R9: The temporary is lost after one cycle. A temporary selection is an error when the previous cycle had no valid result, or when `iss_clause_cont` is 0. An error raises `tmp_err` for one cycle, in place of `res_valid`, and suppresses all register writes.
- R10: While `rst_n` is low, `res_valid`, `tmp_err` and `res_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Instruction present this cycle |
| iss_op | input | 3 | Operation code |
| iss_mode | input | 2 | Element width mode |
| iss_src_a | input | 2 | Source select for operand A |
| iss_src_b | input | 2 | Source select for operand B |
| iss_ra | input | 4 | Register index for operand A |
| iss_rb | input | 4 | Register index for operand B |
| iss_rd | input | 4 | Destination register index |
| iss_imm | input | 32 | Immediate broadcast to all lanes |
| iss_shamt | input | 5 | Left-shift count |
| iss_wb_en | input | 1 | Write result to register file |
| iss_active | input | 4 | Per-thread write enable mask |
| iss_clause_cont | input | 1 | Instruction continues the previous one's clause |
| res_valid | output | 1 | Result valid |
| res_data | output | 128 | Four lane results, lane 0 in the low bits |
| tmp_err | output | 1 | Illegal temporary use by the previous instruction |

## Verification
Each result and each error flag is due exactly one rising edge after its instruction is issued. A register write becomes visible to the instruction issued right after it. The bench drives every instruction on a falling edge and samples outputs on the following falling edge, so exactly one register stage lies between stimulus and check. Back-to-back issues keep the temporary live. A single idle falling-edge step is enough to let it expire, so the temporary-loss cases are timed by inserting or omitting that one idle cycle.

// File: rtl/qsimd_pipe.sv
module qsimd_pipe #(
  parameter int LANES = 4,
  parameter int REGS  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    iss_valid,
  input  logic [2:0]              iss_op,
  input  logic [1:0]              iss_mode,
  input  logic [1:0]              iss_src_a,
  input  logic [1:0]              iss_src_b,
  input  logic [$clog2(REGS)-1:0] iss_ra,
  input  logic [$clog2(REGS)-1:0] iss_rb,
  input  logic [$clog2(REGS)-1:0] iss_rd,
  input  logic [31:0]             iss_imm,
  input  logic [4:0]              iss_shamt,
  input  logic                    iss_wb_en,
  input  logic [LANES-1:0]        iss_active,
  input  logic                    iss_clause_cont,
  output logic                    res_valid,
  output logic [32*LANES-1:0]     res_data,
  output logic                    tmp_err
);
  localparam int W = 32;

  logic [W-1:0] rf [LANES][REGS];
  logic [W-1:0] opa [LANES];
  logic [W-1:0] opb [LANES];
  logic [W-1:0] res [LANES];
  logic use_tmp, tmp_ok, bad, fire;

  assign use_tmp = iss_valid && (iss_src_a == 2'd1 || iss_src_b == 2'd1);
  assign tmp_ok  = res_valid && iss_clause_cont;
  assign bad     = use_tmp && !tmp_ok;
  assign fire    = iss_valid && !bad;

  function automatic logic [W-1:0] pick(input logic [1:0] sel, input logic [W-1:0] regv,
                                        input logic [W-1:0] tmpv, input logic [W-1:0] imm,
                                        input int lane);
    case (sel)
      2'd0:    return regv;
      2'd1:    return tmpv;
      2'd2:    return imm;
      default: return W'(lane);
    endcase
  endfunction

  function automatic logic [W-1:0] alu(input logic [2:0] op, input logic [1:0] mode,
                                       input logic [W-1:0] a, input logic [W-1:0] b,
                                       input logic [4:0] sh);
    logic [W-1:0] r, bb;
    logic [8:0]   s;
    logic         c, sub, head;
    r   = '0;
    sub = (op == 3'd1);
    bb  = sub ? ~b : b;
    c   = sub;
    case (op)
      3'd0, 3'd1: begin
        for (int k = 0; k < 4; k++) begin
          head = (k == 0) || (mode == 2'd2) || (mode == 2'd1 && k == 2);
          if (head) c = sub;
          s = {1'b0, a[8*k +: 8]} + {1'b0, bb[8*k +: 8]} + {8'd0, c};
          r[8*k +: 8] = s[7:0];
          c = s[8];
        end
      end
      3'd2: r = a & b;
      3'd3: r = a | b;
      3'd4: r = a ^ b;
      3'd5: begin
        case (mode)
          2'd1:    for (int h = 0; h < 2; h++) r[16*h +: 16] = a[16*h +: 16] << sh[3:0];
          2'd2:    for (int k = 0; k < 4; k++) r[8*k +: 8] = a[8*k +: 8] << sh[2:0];
          default: r = a << sh;
        endcase
      end
      default: r = a;
    endcase
    return r;
  endfunction

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      opa[l] = pick(iss_src_a, rf[l][iss_ra], res_data[l*W +: W], iss_imm, l);
      opb[l] = pick(iss_src_b, rf[l][iss_rb], res_data[l*W +: W], iss_imm, l);
      res[l] = alu(iss_op, iss_mode, opa[l], opb[l], iss_shamt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      tmp_err   <= 1'b0;
      res_data  <= '0;
      for (int l = 0; l < LANES; l++)
        for (int r = 0; r < REGS; r++)
          rf[l][r] <= '0;
    end else begin
      res_valid <= fire;
      tmp_err   <= bad;
      if (fire) begin
        for (int l = 0; l < LANES; l++) begin
          res_data[l*W +: W] <= res[l];
          if (iss_wb_en && iss_active[l]) rf[l][iss_rd] <= res[l];
        end
      end
    end
  end
endmodule

// File: rtl/qsimd_pipe_chk.sv
module qsimd_pipe_chk #(
  parameter int LANES = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                iss_valid,
  input logic [2:0]          iss_op,
  input logic [1:0]          iss_src_a,
  input logic [1:0]          iss_src_b,
  input logic [31:0]         iss_imm,
  input logic                iss_clause_cont,
  input logic                res_valid,
  input logic [32*LANES-1:0] res_data,
  input logic                tmp_err
);
  AST_RES_FROM_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(iss_valid)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |=> (!res_valid && !tmp_err)); // R2
  AST_PLAIN_ISSUE_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_src_a != 2'd1 && iss_src_b != 2'd1) |=> (res_valid && !tmp_err)); // R2
  AST_AND_IMM_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_op == 3'd2 && iss_src_a == 2'd2 && iss_src_b == 2'd2)
      |=> (res_data == {LANES{$past(iss_imm)}})); // R3
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    tmp_err |-> $past(iss_valid && (iss_src_a == 2'd1 || iss_src_b == 2'd1))); // R9
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(tmp_err && res_valid)); // R9
  AST_CLAUSE_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_src_a == 2'd1 && !iss_clause_cont) |=> tmp_err); // R9
  AST_TMP_EXPIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_src_b == 2'd1 && !res_valid) |=> tmp_err); // R9
endmodule

bind qsimd_pipe qsimd_pipe_chk #(.LANES(LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
  .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_imm(iss_imm),
  .iss_clause_cont(iss_clause_cont), .res_valid(res_valid),
  .res_data(res_data), .tmp_err(tmp_err)
);

// File: tb/qsimd_pipe_tb_top.sv
module qsimd_pipe_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         iss_valid = 1'b0;
  logic [2:0]   iss_op = '0;
  logic [1:0]   iss_mode = '0;
  logic [1:0]   iss_src_a = '0;
  logic [1:0]   iss_src_b = '0;
  logic [3:0]   iss_ra = '0;
  logic [3:0]   iss_rb = '0;
  logic [3:0]   iss_rd = '0;
  logic [31:0]  iss_imm = '0;
  logic [4:0]   iss_shamt = '0;
  logic         iss_wb_en = 1'b0;
  logic [3:0]   iss_active = '0;
  logic         iss_clause_cont = 1'b0;
  logic         res_valid;
  logic [127:0] res_data;
  logic         tmp_err;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  localparam logic [1:0] RG = 2'd0, TM = 2'd1, IM = 2'd2, TI = 2'd3;

  always #4 clk = ~clk;

  qsimd_pipe dut_i (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_mode(iss_mode), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
    .iss_ra(iss_ra), .iss_rb(iss_rb), .iss_rd(iss_rd), .iss_imm(iss_imm),
    .iss_shamt(iss_shamt), .iss_wb_en(iss_wb_en), .iss_active(iss_active),
    .iss_clause_cont(iss_clause_cont), .res_valid(res_valid),
    .res_data(res_data), .tmp_err(tmp_err)
  );

  // op, mode, shamt, A, B, expected per lane
  localparam int NV = 14;
  localparam logic [105:0] VEC [NV] = '{
    {3'd0, 2'd0, 5'd0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000},
    {3'd0, 2'd1, 5'd0, 32'h0001FFFF, 32'h00010001, 32'h00020000},
    {3'd0, 2'd2, 5'd0, 32'h01FF80FF, 32'h01010101, 32'h02008100},
    {3'd1, 2'd0, 5'd0, 32'h00000000, 32'h00000001, 32'hFFFFFFFF},
    {3'd1, 2'd2, 5'd0, 32'h00100005, 32'h01010106, 32'hFF0FFFFF},
    {3'd1, 2'd1, 5'd0, 32'h00050000, 32'h00060001, 32'hFFFFFFFF},
    {3'd2, 2'd0, 5'd0, 32'hF0F0FFFF, 32'h0FF01234, 32'h00F01234},
    {3'd3, 2'd0, 5'd0, 32'h12340000, 32'h00005678, 32'h12345678},
    {3'd4, 2'd0, 5'd0, 32'hFFFF0000, 32'h0F0F0F0F, 32'hF0F00F0F},
    {3'd5, 2'd0, 5'd4, 32'h12345678, 32'h00000000, 32'h23456780},
    {3'd5, 2'd2, 5'd4, 32'h12345678, 32'h00000000, 32'h20406080},
    {3'd5, 2'd1, 5'd9, 32'h00FF00FF, 32'h00000000, 32'hFE00FE00},
    {3'd5, 2'd2, 5'd9, 32'h81818181, 32'h00000000, 32'h02020202},
    {3'd6, 2'd0, 5'd0, 32'hCAFEBABE, 32'h12345678, 32'hCAFEBABE}
  };

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [1:0] mode, input logic [1:0] sa,
                       input logic [1:0] sb, input logic [3:0] ra, input logic [3:0] rb,
                       input logic [3:0] rd, input logic [31:0] imm, input logic [4:0] sh,
                       input logic wb, input logic [3:0] act, input logic cont);
    iss_valid = 1'b1; iss_op = op; iss_mode = mode; iss_src_a = sa; iss_src_b = sb;
    iss_ra = ra; iss_rb = rb; iss_rd = rd; iss_imm = imm; iss_shamt = sh;
    iss_wb_en = wb; iss_active = act; iss_clause_cont = cont;
    @(negedge clk);
  endtask

  task automatic idle();
    iss_valid = 1'b0;
    iss_wb_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset outputs", {125'd0, res_valid, tmp_err, |res_data}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R5 vector table: load A into r1, then r1 op imm(B)
    for (int i = 0; i < NV; i++) begin
      logic [105:0] v;
      v = VEC[i];
      issue(3'd3, 2'd0, IM, IM, 4'd0, 4'd0, 4'd1, v[95:64], 5'd0, 1'b1, 4'hF, 1'b0);
      issue(v[105:103], v[102:101], RG, IM, 4'd1, 4'd0, 4'd0, v[63:32], v[100:96], 1'b0, 4'hF, 1'b0);
      check($sformatf("R3 R4 R5 vector %0d valid", i), {127'd0, res_valid}, 128'd1);
      check($sformatf("R3 R4 R5 vector %0d data", i), res_data, {4{v[31:0]}});
    end

    // R1 per-lane data via thread index, R6 write then read
    issue(3'd3, 2'd0, TI, TI, 4'd0, 4'd0, 4'd2, 32'd0, 5'd0, 1'b1, 4'hF, 1'b0);
    check("R1 thread index lanes", res_data, {32'd3, 32'd2, 32'd1, 32'd0});
    issue(3'd0, 2'd0, RG, IM, 4'd2, 4'd0, 4'd3, 32'h100, 5'd0, 1'b1, 4'hF, 1'b0);
    check("R6 read of just-written reg", res_data, {32'h103, 32'h102, 32'h101, 32'h100});

    // R7 inactive lanes compute but do not write
    issue(3'd3, 2'd0, IM, IM, 4'd0, 4'd0, 4'd4, 32'hAAAA, 5'd0, 1'b1, 4'b0101, 1'b0);
    check("R7 inactive lanes still compute", res_data, {4{32'hAAAA}});
    issue(3'd3, 2'd0, RG, RG, 4'd4, 4'd4, 4'd0, 32'd0, 5'd0, 1'b0, 4'hF, 1'b0);
    check("R7 masked write", res_data, {32'h0, 32'hAAAA, 32'h0, 32'hAAAA});

    // R6 writeback disabled
    issue(3'd3, 2'd0, IM, IM, 4'd0, 4'd0, 4'd5, 32'h55, 5'd0, 1'b0, 4'hF, 1'b0);
    issue(3'd3, 2'd0, RG, RG, 4'd5, 4'd5, 4'd0, 32'd0, 5'd0, 1'b0, 4'hF, 1'b0);
    check("R6 no write when wb disabled", res_data, 128'd0);

    // R8 temporary chain inside a clause
    issue(3'd3, 2'd0, IM, IM, 4'd0, 4'd0, 4'd0, 32'd5, 5'd0, 1'b0, 4'hF, 1'b0);
    check("R8 chain head", res_data, {4{32'd5}});
    issue(3'd0, 2'd0, TM, IM, 4'd0, 4'd0, 4'd0, 32'd3, 5'd0, 1'b0, 4'hF, 1'b1);
    check("R8 temp plus imm", {res_data[126:0], res_valid}, {res_data[126:0], 1'b1});
    check("R8 temp plus imm data", res_data, {4{32'd8}});
    issue(3'd0, 2'd0, TM, TM, 4'd0, 4'd0, 4'd0, 32'd0, 5'd0, 1'b0, 4'hF, 1'b1);
    check("R8 temp plus temp", res_data, {4{32'd16}});
    issue(3'd3, 2'd0, TI, TI, 4'd0, 4'd0, 4'd0, 32'd0, 5'd0, 1'b0, 4'hF, 1'b0);
    issue(3'd0, 2'd0, TM, TM, 4'd0, 4'd0, 4'd0, 32'd0, 5'd0, 1'b0, 4'hF, 1'b1);
    check("R8 per-lane temp", res_data, {32'd6, 32'd4, 32'd2, 32'd0});

    // R2 idle cycle
    idle();
    check("R2 idle gives no result", {126'd0, res_valid, tmp_err}, 128'd0);

    // R9 temp lost after idle, write suppressed
    issue(3'd0, 2'd0, TM, IM, 4'd0, 4'd0, 4'd6, 32'd1, 5'd0, 1'b1, 4'hF, 1'b1);
    check("R9 temp after idle flags error", {126'd0, res_valid, tmp_err}, 128'd1);
    issue(3'd3, 2'd0, RG, RG, 4'd6, 4'd6, 4'd0, 32'd0, 5'd0, 1'b0, 4'hF, 1'b0);
    check("R9 no write on error", {res_data[126:0], res_valid}, {127'd0, 1'b1});
    issue(3'd0, 2'd0, TM, IM, 4'd0, 4'd0, 4'd0, 32'd1, 5'd0, 1'b0, 4'hF, 1'b0);
    check("R9 temp across clause break", {126'd0, res_valid, tmp_err}, 128'd1);
    issue(3'd0, 2'd0, IM, TM, 4'd0, 4'd0, 4'd0, 32'd1, 5'd0, 1'b0, 4'hF, 1'b1);
    check("R9 temp after error", {126'd0, res_valid, tmp_err}, 128'd1);
    idle();
    check("R9 error lasts one cycle", {127'd0, tmp_err}, 128'd0);

    finish_run();
  end
endmodule